// File: doc/BRIEF.md
# Exception Entry and Cause Encoder

This block turns one pending exception into the register values a processor core writes when it enters a handler. A requester holds `req_i` high with an exception number, a cause bitfield, the address of the next instruction and the current machine state word. When the block accepts the request, it registers five values: the return address, the saved state word, the data-fault status word, the new machine state word and the handler address. It then raises a one-cycle `commit_o` pulse, and `flush_o` rises with it so that the caller can invalidate its translation caches.

Some requests are consumed without a vector. A floating-point program exception is dropped when both floating-point exception-mode bits are 0, and so is an unused exception number. Both cases give a one-cycle `drop_o` pulse. External and decrementer interrupts are not consumed while the external-enable bit is 0. They wait for as long as the requester keeps `req_i` high. A machine check that arrives while machine-check-enable is 0 is a checkstop. The block latches `checkstop_o`, takes no vector and stops accepting work until reset.

Top module: `exc_entry`

## Requirements
- R1: The handler address is the exception number shifted left by 8. For number 1 (reset) with the vector-prefix bit (state bit 6) set, 0xFFC00 is added to the number before the shift, which gives 0x0FFC0100.
- R2: The return address is the next-instruction address for numbers 1, 2, 3, 4, 5, 9, 12, 13 and 14. It is that address minus 4 for 6 (alignment), 7 (program) and 8 (FP unavailable). For 2, 5, 6, 8, 9, 12, 13 and 14 the saved state equals the input state and the fault status is 0.
- R3: For a data fault (3), the saved state is the input state with bits 31:16 cleared. The fault status is built from the cause bits as follows, and the earlier items in this list win: 0x40000000 if code[0] (no translation) is set; otherwise 0x08000000 if code[1] (protection) is set; otherwise 0x80000000 if code[2] (not supported) is set, plus 0x04000000 if code[3] (direct store) is also set. On top of that, 0x02000000 is added for code[4] (store) and 0x00100000 for code[5] (external control).
- R4: For an instruction fault (4), the fault status is 0 and the saved state has bits 31:16 cleared. It then gets 0x40000000 if code[0] is set; otherwise 0x10000000 if code[6] (no-execute), code[7] (guarded) or code[3] is set; otherwise 0x08000000.
- R5: For a program exception (7), the saved state has bits 31:16 cleared. It then gets 0x00010000, plus one bit chosen by code[9:8]: 0 = floating-point 0x00100000, 1 = illegal 0x00080000, 2 = privileged 0x00040000, 3 = trap 0x00020000.
- R6: A program exception with code[9:8]=0 while state bits 11 and 8 (FP exception modes) are both 0 gives `drop_o` and neither `commit_o` nor `flush_o`.
- R7: Numbers 5 (external) and 9 (decrementer) give no pulse while state bit 15 (external enable) is 0. They are taken in the cycle after that bit is seen at 1 with the request still held.
- R8: A machine check (2) with state bit 12 at 0 sets `checkstop_o`, which stays set until reset. It produces no commit, and every later request is ignored.
- R9: The new state is the input state with these bits cleared: 18, 15, 14, 13, 11, 10, 9, 8, 5, 4 and 1. Bit 0 is loaded from bit 16, and a taken machine check also clears bit 12.
- R10: Every commit lasts exactly one cycle and comes with `flush_o`. A request seen during a `commit_o` or `drop_o` cycle is ignored.
- R11: Exception numbers 0, 10, 11 and 15 are dropped with `drop_o` and no vector.
- R12: During and after reset every output is 0, `checkstop_o` included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Exception pending, held until consumed |
| type_i | input | 4 | Exception number |
| code_i | input | 10 | Cause bitfield |
| nip_i | input | 32 | Address of the next instruction |
| msr_i | input | 32 | Current machine state word |
| commit_o | output | 1 | One-cycle pulse: exception taken, data outputs valid |
| drop_o | output | 1 | One-cycle pulse: request consumed without a vector |
| flush_o | output | 1 | Translation flush request, with each commit |
| checkstop_o | output | 1 | Sticky checkstop |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved state word with cause bits |
| dsisr_o | output | 32 | Data-fault status word |
| msr_o | output | 32 | New machine state word |
| vector_o | output | 32 | Handler address |

## Verification
A vector table drives every valid exception number with a fixed state word that has enable, privilege, translation and little-endian-interrupt bits set. Comparing the saved state word against the new state word shows whether the upper-half clearing and the cause ORing land in the right output. The data and instruction fault rows combine cause bits, for example no-translation together with protection, to show which cause wins. A row with every state bit set shows which bits the entry clears. A row with the interrupt little-endian bit clear shows that bit 0 follows bit 16. Directed sequences hold an external request through a disabled window, keep a request high across the commit pulse, and drive a checkstop followed by another request. These show deferral, the one-cycle pulse and the stickiness of the checkstop.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  parameter int XLEN      = 32;
  parameter int TYPE_W    = 4;
  parameter int CODE_W    = 10;
  parameter int VEC_SHIFT = 8;
  parameter logic [19:0] HI_VEC_ADD = 20'hFFC00;

  typedef enum logic [TYPE_W-1:0] {
    EXC_NONE  = 4'd0,  EXC_RESET = 4'd1,  EXC_MCHK  = 4'd2,  EXC_DFLT = 4'd3,
    EXC_IFLT  = 4'd4,  EXC_EXT   = 4'd5,  EXC_ALIGN = 4'd6,  EXC_PROG = 4'd7,
    EXC_NOFP  = 4'd8,  EXC_DECR  = 4'd9,  EXC_SYSC  = 4'd12, EXC_TRACE = 4'd13,
    EXC_FPAST = 4'd14
  } exc_e;

  typedef enum logic [1:0] {PS_FP = 2'd0, PS_ILL = 2'd1, PS_PRIV = 2'd2, PS_TRAP = 2'd3} psub_e;

  // machine state bit positions
  localparam int MB_LE  = 0;
  localparam int MB_RI  = 1;
  localparam int MB_DR  = 4;
  localparam int MB_IR  = 5;
  localparam int MB_IP  = 6;
  localparam int MB_FE1 = 8;
  localparam int MB_BE  = 9;
  localparam int MB_SE  = 10;
  localparam int MB_FE0 = 11;
  localparam int MB_ME  = 12;
  localparam int MB_FP  = 13;
  localparam int MB_PR  = 14;
  localparam int MB_EE  = 15;
  localparam int MB_ILE = 16;
  localparam int MB_POW = 18;

  // cause bitfield positions
  localparam int CB_XLATE  = 0;
  localparam int CB_PROT   = 1;
  localparam int CB_NSUP   = 2;
  localparam int CB_DIRECT = 3;
  localparam int CB_STORE  = 4;
  localparam int CB_EXTCTL = 5;
  localparam int CB_NOEXEC = 6;
  localparam int CB_GUARD  = 7;
  localparam int CB_PSUB   = 8;

  // status word bit positions
  localparam int SB_NSUP   = 31;
  localparam int SB_XLATE  = 30;
  localparam int SB_NOEXEC = 28;
  localparam int SB_PROT   = 27;
  localparam int SB_DIRECT = 26;
  localparam int SB_STORE  = 25;
  localparam int SB_EXTCTL = 20;
  localparam int SB_PFP    = 20;
  localparam int SB_PILL   = 19;
  localparam int SB_PPRIV  = 18;
  localparam int SB_PTRAP  = 17;
  localparam int SB_PANY   = 16;
  localparam int HALF      = XLEN / 2;
endpackage

// File: rtl/exc_gate.sv
module exc_gate
  import exc_entry_pkg::*;
(
  input  logic  valid_i,
  input  exc_e  typ_i,
  input  psub_e psub_i,
  input  logic  ee_i,
  input  logic  me_i,
  input  logic  fe0_i,
  input  logic  fe1_i,
  output logic  take_o,
  output logic  drop_o,
  output logic  stop_o
);
  always_comb begin
    take_o = 1'b0;
    drop_o = 1'b0;
    stop_o = 1'b0;
    if (valid_i) begin
      unique case (typ_i)
        EXC_EXT, EXC_DECR: take_o = ee_i;          // defer while disabled
        EXC_MCHK: begin
          take_o = me_i;
          stop_o = !me_i;
        end
        EXC_PROG: begin
          if (psub_i == PS_FP && !fe0_i && !fe1_i) drop_o = 1'b1;
          else                                     take_o = 1'b1;
        end
        EXC_RESET, EXC_DFLT, EXC_IFLT, EXC_ALIGN, EXC_NOFP,
        EXC_SYSC, EXC_TRACE, EXC_FPAST: take_o = 1'b1;
        default: drop_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/exc_cause_enc.sv
module exc_cause_enc
  import exc_entry_pkg::*;
(
  input  exc_e              typ_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   msr_i,
  output logic [XLEN-1:0]   srr1_o,
  output logic [XLEN-1:0]   dsisr_o,
  output logic              cur_o
);
  logic [XLEN-1:0] low_half;
  logic [XLEN-1:0] prog_bits;
  psub_e           psub;

  assign low_half = {{HALF{1'b0}}, msr_i[HALF-1:0]};
  assign psub     = psub_e'(code_i[CB_PSUB +: 2]);

  // one program cause bit per sub-kind, placed by generate
  for (genvar g = 0; g < 4; g++) begin : g_prog
    assign prog_bits[SB_PFP-g] = (psub == psub_e'(g));
  end
  assign prog_bits[SB_PFP-4:0]      = '0;
  assign prog_bits[XLEN-1:SB_PFP+1] = '0;

  always_comb begin
    srr1_o  = msr_i;
    dsisr_o = '0;
    cur_o   = 1'b0;
    unique case (typ_i)
      EXC_DFLT: begin
        srr1_o = low_half;
        if (code_i[CB_XLATE])     dsisr_o[SB_XLATE] = 1'b1;
        else if (code_i[CB_PROT]) dsisr_o[SB_PROT]  = 1'b1;
        else if (code_i[CB_NSUP]) begin
          dsisr_o[SB_NSUP]   = 1'b1;
          dsisr_o[SB_DIRECT] = code_i[CB_DIRECT];
        end
        dsisr_o[SB_STORE]  = code_i[CB_STORE];
        dsisr_o[SB_EXTCTL] = code_i[CB_EXTCTL];
      end
      EXC_IFLT: begin
        srr1_o = low_half;
        if (code_i[CB_XLATE])
          srr1_o[SB_XLATE] = 1'b1;
        else if (code_i[CB_NOEXEC] || code_i[CB_GUARD] || code_i[CB_DIRECT])
          srr1_o[SB_NOEXEC] = 1'b1;
        else
          srr1_o[SB_PROT] = 1'b1;
      end
      EXC_PROG: begin
        srr1_o = low_half | prog_bits;
        srr1_o[SB_PANY] = 1'b1;
        cur_o  = 1'b1;
      end
      EXC_ALIGN, EXC_NOFP: cur_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_msr_next.sv
module exc_msr_next
  import exc_entry_pkg::*;
(
  input  exc_e            typ_i,
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] vec_o
);
  localparam logic [XLEN-1:0] CLR_MASK =
      (XLEN'(1) << MB_POW) | (XLEN'(1) << MB_EE)  | (XLEN'(1) << MB_PR)  |
      (XLEN'(1) << MB_FP)  | (XLEN'(1) << MB_FE0) | (XLEN'(1) << MB_SE)  |
      (XLEN'(1) << MB_BE)  | (XLEN'(1) << MB_FE1) | (XLEN'(1) << MB_IR)  |
      (XLEN'(1) << MB_DR)  | (XLEN'(1) << MB_RI);

  logic [XLEN-1:0] num;

  always_comb begin
    msr_o        = msr_i & ~CLR_MASK;
    msr_o[MB_LE] = msr_i[MB_ILE];
    if (typ_i == EXC_MCHK) msr_o[MB_ME] = 1'b0;
    num = XLEN'(typ_i);
    if (typ_i == EXC_RESET && msr_i[MB_IP]) num = num + XLEN'(HI_VEC_ADD);
    vec_o = num << VEC_SHIFT;
  end
endmodule

// File: rtl/exc_entry.sv
module exc_entry
  import exc_entry_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   nip_i,
  input  logic [XLEN-1:0]   msr_i,
  output logic              commit_o,
  output logic              drop_o,
  output logic              flush_o,
  output logic              checkstop_o,
  output logic [XLEN-1:0]   srr0_o,
  output logic [XLEN-1:0]   srr1_o,
  output logic [XLEN-1:0]   dsisr_o,
  output logic [XLEN-1:0]   msr_o,
  output logic [XLEN-1:0]   vector_o
);
  exc_e            typ;
  logic            valid, take, drop, stop, cur;
  logic [XLEN-1:0] srr1_d, dsisr_d, msr_d, vec_d, srr0_d;

  assign typ   = exc_e'(type_i);
  assign valid = req_i && !commit_o && !drop_o && !checkstop_o;

  exc_gate i_gate (
    .valid_i (valid),
    .typ_i   (typ),
    .psub_i  (psub_e'(code_i[CB_PSUB +: 2])),
    .ee_i    (msr_i[MB_EE]),
    .me_i    (msr_i[MB_ME]),
    .fe0_i   (msr_i[MB_FE0]),
    .fe1_i   (msr_i[MB_FE1]),
    .take_o  (take),
    .drop_o  (drop),
    .stop_o  (stop)
  );

  exc_cause_enc i_cause (
    .typ_i   (typ),
    .code_i  (code_i),
    .msr_i   (msr_i),
    .srr1_o  (srr1_d),
    .dsisr_o (dsisr_d),
    .cur_o   (cur)
  );

  exc_msr_next i_next (
    .typ_i (typ),
    .msr_i (msr_i),
    .msr_o (msr_d),
    .vec_o (vec_d)
  );

  assign srr0_d = cur ? nip_i - XLEN'(4) : nip_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      commit_o    <= 1'b0;
      drop_o      <= 1'b0;
      flush_o     <= 1'b0;
      checkstop_o <= 1'b0;
    end else begin
      commit_o <= take;
      drop_o   <= drop;
      flush_o  <= take;
      if (stop) checkstop_o <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      srr0_o   <= '0;
      srr1_o   <= '0;
      dsisr_o  <= '0;
      msr_o    <= '0;
      vector_o <= '0;
    end else if (take) begin
      srr0_o   <= srr0_d;
      srr1_o   <= srr1_d;
      dsisr_o  <= dsisr_d;
      msr_o    <= msr_d;
      vector_o <= vec_d;
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [TYPE_W-1:0] type_i,
  input logic [XLEN-1:0]   msr_i,
  input logic              commit_o,
  input logic              drop_o,
  input logic              checkstop_o,
  input logic [XLEN-1:0]   srr1_o,
  input logic [XLEN-1:0]   msr_o,
  input logic [XLEN-1:0]   vector_o
);
  logic idle_req;
  assign idle_req = req_i && !commit_o && !drop_o && !checkstop_o;

  AST_VEC_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> vector_o[VEC_SHIFT-1:0] == '0); // R1
  AST_PROG_ANY_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o && vector_o == (XLEN'(EXC_PROG) << VEC_SHIFT)) |-> srr1_o[SB_PANY]); // R5
  AST_DEFER_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_req && (type_i == EXC_EXT || type_i == EXC_DECR) && !msr_i[MB_EE])
      |=> (!commit_o && !drop_o)); // R7
  AST_CHECKSTOP_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_req && type_i == EXC_MCHK && !msr_i[MB_ME]) |=> (checkstop_o && !commit_o)); // R8
  AST_CHECKSTOP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checkstop_o |=> checkstop_o); // R8
  AST_MSR_ENTRY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (!msr_o[MB_EE] && !msr_o[MB_PR] && !msr_o[MB_IR] && !msr_o[MB_DR])); // R9
  AST_LE_FROM_ILE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> msr_o[MB_LE] == $past(msr_i[MB_ILE])); // R9
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (!commit_o && !drop_o)); // R10
endmodule

bind exc_entry exc_entry_chk i_exc_entry_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .type_i      (type_i),
  .msr_i       (msr_i),
  .commit_o    (commit_o),
  .drop_o      (drop_o),
  .checkstop_o (checkstop_o),
  .srr1_o      (srr1_o),
  .msr_o       (msr_o),
  .vector_o    (vector_o)
);

// File: tb/test_exc_entry.sv
module test_exc_entry;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  type_i = '0;
  logic [9:0]  code_i = '0;
  logic [31:0] nip_i = 32'h1000_0040;
  logic [31:0] msr_i = '0;
  logic        commit_o, drop_o, flush_o, checkstop_o;
  logic [31:0] srr0_o, srr1_o, dsisr_o, msr_o, vector_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  exc_entry i_exc_entry (.*);

  typedef struct packed {
    logic [3:0]  rq;
    logic [3:0]  typ;
    logic [9:0]  code;
    logic [31:0] msr;
    logic        take;
    logic        drop;
    logic        cur;
    logic [31:0] srr1;
    logic [31:0] dsisr;
    logic [31:0] nmsr;
    logic [31:0] vec;
  } row_t;

  localparam int NROW = 27;
  localparam logic [31:0] M = 32'h0001_D032;
  localparam logic [31:0] U = 32'h0000_D032;
  localparam logic [31:0] N = 32'h0001_1001;

  localparam row_t TBL [NROW] = '{
    '{4'd3, 4'd3,  10'h012, M, 1'b1, 1'b0, 1'b0, U, 32'h0A00_0000, N, 32'h300},          // R3
    '{4'd3, 4'd3,  10'h001, M, 1'b1, 1'b0, 1'b0, U, 32'h4000_0000, N, 32'h300},          // R3
    '{4'd3, 4'd3,  10'h02C, M, 1'b1, 1'b0, 1'b0, U, 32'h8410_0000, N, 32'h300},          // R3
    '{4'd3, 4'd3,  10'h003, M, 1'b1, 1'b0, 1'b0, U, 32'h4000_0000, N, 32'h300},          // R3
    '{4'd4, 4'd4,  10'h001, M, 1'b1, 1'b0, 1'b0, 32'h4000_D032, 32'h0, N, 32'h400},      // R4
    '{4'd4, 4'd4,  10'h080, M, 1'b1, 1'b0, 1'b0, 32'h1000_D032, 32'h0, N, 32'h400},      // R4
    '{4'd4, 4'd4,  10'h002, M, 1'b1, 1'b0, 1'b0, 32'h0800_D032, 32'h0, N, 32'h400},      // R4
    '{4'd5, 4'd7,  10'h100, M, 1'b1, 1'b0, 1'b1, 32'h0009_D032, 32'h0, N, 32'h700},      // R5
    '{4'd5, 4'd7,  10'h200, M, 1'b1, 1'b0, 1'b1, 32'h0005_D032, 32'h0, N, 32'h700},      // R5
    '{4'd5, 4'd7,  10'h300, M, 1'b1, 1'b0, 1'b1, 32'h0003_D032, 32'h0, N, 32'h700},      // R5
    '{4'd5, 4'd7,  10'h000, 32'h0001_D832, 1'b1, 1'b0, 1'b1, 32'h0011_D832, 32'h0, N, 32'h700}, // R5
    '{4'd2, 4'd6,  10'h000, M, 1'b1, 1'b0, 1'b1, M, 32'h0, N, 32'h600},                  // R2
    '{4'd2, 4'd8,  10'h000, M, 1'b1, 1'b0, 1'b1, M, 32'h0, N, 32'h800},                  // R2
    '{4'd2, 4'd12, 10'h000, M, 1'b1, 1'b0, 1'b0, M, 32'h0, N, 32'hC00},                  // R2
    '{4'd2, 4'd9,  10'h000, M, 1'b1, 1'b0, 1'b0, M, 32'h0, N, 32'h900},                  // R2
    '{4'd2, 4'd5,  10'h000, M, 1'b1, 1'b0, 1'b0, M, 32'h0, N, 32'h500},                  // R2
    '{4'd2, 4'd13, 10'h000, M, 1'b1, 1'b0, 1'b0, M, 32'h0, N, 32'hD00},                  // R2
    '{4'd2, 4'd14, 10'h000, M, 1'b1, 1'b0, 1'b0, M, 32'h0, N, 32'hE00},                  // R2
    '{4'd1, 4'd1,  10'h000, M, 1'b1, 1'b0, 1'b0, M, 32'h0, N, 32'h100},                  // R1
    '{4'd1, 4'd1,  10'h000, 32'h0001_D072, 1'b1, 1'b0, 1'b0, 32'h0001_D072, 32'h0, 32'h0001_1041, 32'h0FFC_0100}, // R1
    '{4'd9, 4'd2,  10'h000, M, 1'b1, 1'b0, 1'b0, M, 32'h0, 32'h0001_0001, 32'h200},      // R9
    '{4'd9, 4'd12, 10'h000, U, 1'b1, 1'b0, 1'b0, U, 32'h0, 32'h0000_1000, 32'hC00},      // R9
    '{4'd9, 4'd12, 10'h000, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF, 32'h0, 32'hFFFB_10CD, 32'hC00}, // R9
    '{4'd6, 4'd7,  10'h000, M, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0},            // R6
    '{4'd11, 4'd0, 10'h000, M, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0},            // R11
    '{4'd11, 4'd10, 10'h000, M, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0},           // R11
    '{4'd11, 4'd15, 10'h000, M, 1'b0, 1'b1, 1'b0, 32'h0, 32'h0, 32'h0, 32'h0}            // R11
  };

  task automatic chk(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R12: reset state
    repeat (2) @(negedge clk_i);
    chk(12, "commit in reset", {31'b0, commit_o}, 32'h0);
    chk(12, "checkstop in reset", {31'b0, checkstop_o}, 32'h0);
    chk(12, "vector in reset", vector_o, 32'h0);
    chk(12, "srr0 in reset", srr0_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NROW; i++) begin
      req_i  = 1'b1;
      type_i = TBL[i].typ;
      code_i = TBL[i].code;
      msr_i  = TBL[i].msr;
      @(negedge clk_i);
      req_i = 1'b0;
      chk(TBL[i].rq, "commit", {31'b0, commit_o}, {31'b0, TBL[i].take});
      chk(TBL[i].rq, "drop", {31'b0, drop_o}, {31'b0, TBL[i].drop});
      chk(10, "flush with commit", {31'b0, flush_o}, {31'b0, TBL[i].take}); // R10
      if (TBL[i].take) begin
        chk(2, "srr0", srr0_o, TBL[i].cur ? nip_i - 32'd4 : nip_i); // R2
        chk(TBL[i].rq, "srr1", srr1_o, TBL[i].srr1);
        chk(TBL[i].rq, "dsisr", dsisr_o, TBL[i].dsisr);
        chk(9, "new msr", msr_o, TBL[i].nmsr); // R9
        chk(1, "vector", vector_o, TBL[i].vec); // R1
      end
      @(negedge clk_i);
    end

    // R7: external interrupt held while disabled, taken once enabled
    req_i  = 1'b1;
    type_i = 4'd5;
    code_i = '0;
    msr_i  = M & ~32'h8000;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      chk(7, "deferred commit", {31'b0, commit_o}, 32'h0);
      chk(7, "deferred drop", {31'b0, drop_o}, 32'h0);
    end
    msr_i = M;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(7, "taken after enable", {31'b0, commit_o}, 32'h1);
    chk(7, "vector after enable", vector_o, 32'h500);
    @(negedge clk_i);

    // R10: request held across the pulse is ignored in the pulse cycle
    req_i  = 1'b1;
    type_i = 4'd12;
    msr_i  = M;
    @(negedge clk_i);
    chk(10, "pulse high", {31'b0, commit_o}, 32'h1);
    @(negedge clk_i);
    req_i = 1'b0;
    chk(10, "pulse one cycle", {31'b0, commit_o}, 32'h0);
    chk(10, "flush one cycle", {31'b0, flush_o}, 32'h0);
    @(negedge clk_i);

    // R8: checkstop
    req_i  = 1'b1;
    type_i = 4'd2;
    msr_i  = M & ~32'h1000;
    @(negedge clk_i);
    req_i = 1'b0;
    chk(8, "checkstop set", {31'b0, checkstop_o}, 32'h1);
    chk(8, "no commit on checkstop", {31'b0, commit_o}, 32'h0);
    req_i  = 1'b1;
    type_i = 4'd12;
    msr_i  = M;
    @(negedge clk_i);
    chk(8, "request ignored after checkstop", {31'b0, commit_o | drop_o}, 32'h0);
    @(negedge clk_i);
    req_i = 1'b0;
    chk(8, "checkstop sticky", {31'b0, checkstop_o}, 32'h1);
    chk(8, "still no commit", {31'b0, commit_o}, 32'h0);

    // R12: reset clears checkstop and data
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(12, "checkstop cleared", {31'b0, checkstop_o}, 32'h0);
    chk(12, "msr out cleared", msr_o, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    finish_run();
  end
endmodule